// File: doc/BRIEF.md
# Register Rename and Commit Unit

This block gives every instruction that writes a register a fresh physical tag at decode time, whether or not a hazard exists. An alias table tells, for each architected register, whether its newest value still lives in the committed register file or is pending under a physical tag. Spare tags wait in a first-in first-out pool. The pool starts full and hands out tags in the order it stores them.

Rename is a valid/ready stream. The decoder presents `ren_valid` with up to two source indices and an optional destination. The lookup answers in the same cycle: `src_in_arf`, `src_tag`, `src_val` and `dst_tag`. The transfer happens on a clock edge where `ren_valid` and `ren_ready` are both high. The block holds `ren_ready` low only when the request has a destination and the pool is empty. A request with no destination is always accepted. The decoder must keep its request steady while `ren_ready` is low.

Commit is a plain valid strobe with no back-pressure. It writes the result into the committed file and returns the tag to the pool. It points the alias entry back at the committed file only if that entry still holds the committing tag. Source lookups see the alias table and the committed file as they stood before the current cycle's updates.

Top module: `rename_commit_unit`

## Requirements
- R1: After reset, every source reports `src_in_arf`=1 with value 0, `ren_ready` is 1, and the first destination tags handed out are 0, 1, 2 and so on in sequence.
- R2: Each accepted rename with `ren_has_dst`=1 takes the tag shown on `dst_tag` out of the pool, even when no source matches any earlier destination.
- R3: After a rename of destination d with tag t, a later source lookup of d gives `src_in_arf`=0 and `src_tag`=t.
- R4: A source whose entry points at the committed file gives `src_in_arf`=1, and `src_val` carries that register's committed value.
- R5: The pool hands out returned tags in the order they were returned, after the tags already queued, not in numeric order.
- R6: With the pool empty, `ren_ready` is 0 for a request with `ren_has_dst`=1 and no tag is taken. A request with `ren_has_dst`=0 still sees `ren_ready`=1.
- R7: A commit writes `cmt_data` into committed register `cmt_arch`.
- R8: A commit whose tag equals the entry's current tag returns that entry to the committed file, so later lookups give `src_in_arf`=1.
- R9: A commit whose tag differs from the entry's current tag leaves the entry unchanged.
- R10: A committed tag goes back to the tail of the pool and is handed out again later.
- R11: When a rename and a commit touch the same entry in the same cycle, the rename's new tag wins.
- R12: A source lookup sees the mapping from before any rename in the same cycle. A request whose source equals its destination reads the older mapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | Rename request present |
| ren_ready | output | 1 | Rename request can be accepted |
| ren_has_dst | input | 1 | Request writes a destination register |
| ren_dst | input | 3 | Architected destination index |
| ren_src | input | 2x3 | Architected source indices |
| src_in_arf | output | 2 | Per source: 1 = value is in the committed file |
| src_tag | output | 2x4 | Per source: physical tag when not in the committed file |
| src_val | output | 2x32 | Per source: committed file value |
| dst_tag | output | 4 | Tag given to the destination on acceptance |
| cmt_valid | input | 1 | Commit strobe |
| cmt_arch | input | 3 | Architected register being committed |
| cmt_tag | input | 4 | Physical tag being released |
| cmt_data | input | 32 | Result value to make official |

## Verification
The checks assume a well-behaved pipeline. Each commit carries a tag that is currently allocated, with the architected register it was allocated for. No tag is committed twice. Because of this the pool never overflows, and the table's checks can index by the incoming architected register. All indices stay below the register count. The bench follows these rules by committing only tags it received from `dst_tag` for the registers it named. Each scenario starts from a fresh reset.

// File: rtl/rn_pkg.sv
package rn_pkg;
  // Where a source operand currently lives.
  typedef enum logic {
    LOC_PHYS = 1'b0,
    LOC_ARF  = 1'b1
  } src_loc_e;

  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rn_free_fifo.sv
module rn_free_fifo #(
  parameter int DEPTH = 16,
  parameter int TW    = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [TW-1:0] push_tag,
  input  logic          pop,
  output logic [TW-1:0] head_tag,
  output logic          empty
);
  localparam int CW = TW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [TW-1:0] slot_q [DEPTH];
  logic [TW-1:0] rd_q, wr_q;
  logic [CW-1:0] count_q;

  function automatic logic [TW-1:0] bump(input logic [TW-1:0] p);
    return (p == TW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) slot_q[i] <= TW'(i);
      rd_q    <= '0;
      wr_q    <= '0;
      count_q <= FULL_CNT;
    end else begin
      if (push) begin
        slot_q[wr_q] <= push_tag;
        wr_q         <= bump(wr_q);
      end
      if (pop) rd_q <= bump(rd_q);
      if (push && !pop)      count_q <= count_q + 1'b1;
      else if (pop && !push) count_q <= count_q - 1'b1;
    end
  end

  assign head_tag = slot_q[rd_q];
  assign empty    = (count_q == '0);

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> count_q != '0);
  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> (count_q < FULL_CNT) || pop);
  // R10
  push_grow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop) |=> count_q == $past(count_q) + 1'b1);
  // R2
  pop_shrink_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !push) |=> count_q == $past(count_q) - 1'b1);
endmodule

// File: rtl/rn_alias_table.sv
module rn_alias_table #(
  parameter int ARCH_REGS = 6,
  parameter int AW        = 3,
  parameter int TW        = 4,
  parameter int NSRC      = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [NSRC-1:0][AW-1:0]   rd_idx,
  output logic [NSRC-1:0]           rd_mapped,
  output logic [NSRC-1:0][TW-1:0]   rd_tag,
  input  logic                      wr_en,
  input  logic [AW-1:0]             wr_idx,
  input  logic [TW-1:0]             wr_tag,
  input  logic                      clr_en,
  input  logic [AW-1:0]             clr_idx,
  input  logic [TW-1:0]             clr_tag
);
  logic [ARCH_REGS-1:0] mapped_q;
  logic [TW-1:0]        tag_q [ARCH_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mapped_q <= '0;
      for (int e = 0; e < ARCH_REGS; e++) tag_q[e] <= '0;
    end else begin
      for (int e = 0; e < ARCH_REGS; e++) begin
        if (wr_en && wr_idx == AW'(e)) begin
          mapped_q[e] <= 1'b1;
          tag_q[e]    <= wr_tag;
        end else if (clr_en && clr_idx == AW'(e) && mapped_q[e] && tag_q[e] == clr_tag) begin
          mapped_q[e] <= 1'b0;
        end
      end
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_rd
    assign rd_mapped[s] = mapped_q[rd_idx[s]];
    assign rd_tag[s]    = tag_q[rd_idx[s]];
  end

  // R3
  rename_map_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> mapped_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag));
  // R8
  commit_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(wr_en && wr_idx == clr_idx) && mapped_q[clr_idx] && tag_q[clr_idx] == clr_tag)
    |=> !mapped_q[$past(clr_idx)]);
  // R9
  younger_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_en && !(wr_en && wr_idx == clr_idx) && mapped_q[clr_idx] && tag_q[clr_idx] != clr_tag)
    |=> mapped_q[$past(clr_idx)] && tag_q[$past(clr_idx)] == $past(tag_q[clr_idx]));
endmodule

// File: rtl/rn_arch_file.sv
module rn_arch_file #(
  parameter int ARCH_REGS = 6,
  parameter int AW        = 3,
  parameter int DW        = 32,
  parameter int NSRC      = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [AW-1:0]           wr_idx,
  input  logic [DW-1:0]           wr_data,
  input  logic [NSRC-1:0][AW-1:0] rd_idx,
  output logic [NSRC-1:0][DW-1:0] rd_data
);
  logic [DW-1:0] reg_q [ARCH_REGS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int e = 0; e < ARCH_REGS; e++) reg_q[e] <= '0;
    end else if (wr_en) begin
      reg_q[wr_idx] <= wr_data;
    end
  end

  for (genvar s = 0; s < NSRC; s++) begin : g_rd
    assign rd_data[s] = reg_q[rd_idx[s]];
  end

  // R7
  arf_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> reg_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/rename_commit_unit.sv
module rename_commit_unit
  import rn_pkg::*;
#(
  parameter int ARCH_REGS = 6,
  parameter int PHYS_TAGS = 16,
  parameter int DW        = 32,
  parameter int NSRC      = 2,
  localparam int AW       = idx_w(ARCH_REGS),
  localparam int TW       = idx_w(PHYS_TAGS)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ren_valid,
  output logic                    ren_ready,
  input  logic                    ren_has_dst,
  input  logic [AW-1:0]           ren_dst,
  input  logic [NSRC-1:0][AW-1:0] ren_src,
  output logic [NSRC-1:0]         src_in_arf,
  output logic [NSRC-1:0][TW-1:0] src_tag,
  output logic [NSRC-1:0][DW-1:0] src_val,
  output logic [TW-1:0]           dst_tag,
  input  logic                    cmt_valid,
  input  logic [AW-1:0]           cmt_arch,
  input  logic [TW-1:0]           cmt_tag,
  input  logic [DW-1:0]           cmt_data
);
  logic            pool_empty;
  logic [TW-1:0]   pool_head;
  logic            alloc;
  logic [NSRC-1:0] rd_mapped;

  assign ren_ready = !ren_has_dst || !pool_empty;
  assign alloc     = ren_valid && ren_ready && ren_has_dst;
  assign dst_tag   = pool_head;

  rn_free_fifo #(.DEPTH(PHYS_TAGS), .TW(TW)) pool_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (cmt_valid),
    .push_tag (cmt_tag),
    .pop      (alloc),
    .head_tag (pool_head),
    .empty    (pool_empty)
  );

  rn_alias_table #(.ARCH_REGS(ARCH_REGS), .AW(AW), .TW(TW), .NSRC(NSRC)) rat_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_idx    (ren_src),
    .rd_mapped (rd_mapped),
    .rd_tag    (src_tag),
    .wr_en     (alloc),
    .wr_idx    (ren_dst),
    .wr_tag    (pool_head),
    .clr_en    (cmt_valid),
    .clr_idx   (cmt_arch),
    .clr_tag   (cmt_tag)
  );

  rn_arch_file #(.ARCH_REGS(ARCH_REGS), .AW(AW), .DW(DW), .NSRC(NSRC)) arf_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (cmt_valid),
    .wr_idx  (cmt_arch),
    .wr_data (cmt_data),
    .rd_idx  (ren_src),
    .rd_data (src_val)
  );

  for (genvar s = 0; s < NSRC; s++) begin : g_loc
    src_loc_e loc;
    assign loc           = rd_mapped[s] ? LOC_PHYS : LOC_ARF;
    assign src_in_arf[s] = (loc == LOC_ARF);
  end

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ren_valid && ren_has_dst && pool_empty && !cmt_valid) |=> pool_empty);
  // R11
  rename_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc && cmt_valid && cmt_arch == ren_dst) |=> !rd_mapped[0] || ren_src[0] != $past(ren_dst)
      || src_tag[0] == $past(pool_head));
endmodule

// File: tb/rename_commit_unit_tb_top.sv
module rename_commit_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic            ren_valid, ren_ready, ren_has_dst;
  logic [2:0]      ren_dst;
  logic [1:0][2:0] ren_src;
  logic [1:0]      src_in_arf;
  logic [1:0][3:0] src_tag;
  logic [1:0][31:0] src_val;
  logic [3:0]      dst_tag;
  logic            cmt_valid;
  logic [2:0]      cmt_arch;
  logic [3:0]      cmt_tag;
  logic [31:0]     cmt_data;

  int checks = 0;
  int errors = 0;

  rename_commit_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_ready(ren_ready),
    .ren_has_dst(ren_has_dst), .ren_dst(ren_dst), .ren_src(ren_src),
    .src_in_arf(src_in_arf), .src_tag(src_tag), .src_val(src_val), .dst_tag(dst_tag),
    .cmt_valid(cmt_valid), .cmt_arch(cmt_arch), .cmt_tag(cmt_tag), .cmt_data(cmt_data)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string req, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Drive one cycle's inputs after the falling edge, then settle before the rising edge.
  task automatic step(input logic rv, input logic hd, input int d, input int s0, input int s1,
                      input logic cv, input int ca, input int ct, input logic [31:0] cd);
    @(negedge clk);
    ren_valid = rv; ren_has_dst = hd; ren_dst = 3'(d);
    ren_src[0] = 3'(s0); ren_src[1] = 3'(s1);
    cmt_valid = cv; cmt_arch = 3'(ca); cmt_tag = 4'(ct); cmt_data = cd;
    #5;
  endtask

  task automatic idle_look(input int s0, input int s1);
    step(1'b0, 1'b0, 0, s0, s1, 1'b0, 0, 0, 32'h0);
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0;
    ren_valid = 0; ren_has_dst = 0; ren_dst = 0; ren_src = '0;
    cmt_valid = 0; cmt_arch = 0; cmt_tag = 0; cmt_data = 0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    idle_look(0, 5);
    chk(ren_ready, 1, "R1", "ready after reset");
    chk(src_in_arf, 2'b11, "R1", "sources in arf");
    chk(src_val[0], 0, "R1", "value r0");
    chk(src_val[1], 0, "R1", "value r5");
    chk(dst_tag, 0, "R1", "first tag");
  endtask

  task automatic t_alloc;
    do_reset();
    step(1, 1, 1, 2, 3, 0, 0, 0, 0);
    chk(dst_tag, 0, "R2", "tag for independent rename");
    chk(src_in_arf, 2'b11, "R2", "no hazard sources");
    step(1, 1, 2, 1, 0, 0, 0, 0, 0);
    chk(dst_tag, 1, "R1", "second tag in sequence");
    chk(src_in_arf[0], 0, "R3", "r1 renamed");
    chk(src_tag[0], 0, "R3", "r1 tag");
    chk(src_in_arf[1], 1, "R4", "r0 still in arf");
    idle_look(2, 1);
    chk(src_tag[0], 1, "R3", "r2 tag");
  endtask

  task automatic t_self_src;
    do_reset();
    step(1, 1, 3, 3, 3, 0, 0, 0, 0);
    chk(src_in_arf, 2'b11, "R12", "self source sees old mapping");
    step(1, 1, 4, 3, 4, 0, 0, 0, 0);
    chk(src_in_arf[0], 0, "R12", "next sees new mapping");
    chk(src_tag[0], 0, "R12", "next tag");
    chk(src_in_arf[1], 1, "R12", "own dst r4 old mapping");
  endtask

  task automatic t_commit_drain;
    do_reset();
    step(1, 1, 1, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 1, 0, 32'hAB);
    idle_look(1, 2);
    chk(src_in_arf[0], 1, "R8", "matching commit returns to arf");
    chk(src_val[0], 32'hAB, "R7", "committed value");
    for (int i = 1; i < 16; i++) begin
      step(1, 1, 0, 0, 0, 0, 0, 0, 0);
      chk(dst_tag, i, "R2", "drain order");
    end
    step(1, 1, 0, 0, 0, 0, 0, 0, 0);
    chk(dst_tag, 0, "R10", "freed tag reused");
    chk(ren_ready, 1, "R10", "ready for freed tag");
    step(1, 1, 5, 0, 0, 0, 0, 0, 0);
    chk(ren_ready, 0, "R6", "stall on empty pool");
    step(1, 0, 5, 5, 0, 0, 0, 0, 0);
    chk(ren_ready, 1, "R6", "no-dst accepted when empty");
    chk(src_in_arf[0], 1, "R6", "stalled rename left r5 unmapped");
  endtask

  task automatic t_younger;
    do_reset();
    step(1, 1, 2, 0, 0, 0, 0, 0, 0);
    step(1, 1, 2, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2, 0, 32'h11);
    idle_look(2, 2);
    chk(src_in_arf[0], 0, "R9", "younger writer keeps entry");
    chk(src_tag[0], 1, "R9", "younger tag kept");
    step(0, 0, 0, 0, 0, 1, 2, 1, 32'h22);
    idle_look(2, 2);
    chk(src_in_arf[0], 1, "R8", "last writer releases entry");
    chk(src_val[0], 32'h22, "R7", "latest value");
  endtask

  task automatic t_same_cycle;
    do_reset();
    step(1, 1, 5, 0, 0, 0, 0, 0, 0);
    step(1, 1, 5, 0, 0, 1, 5, 0, 32'h55);
    chk(dst_tag, 1, "R11", "new tag");
    idle_look(5, 5);
    chk(src_in_arf[0], 0, "R11", "rename wins");
    chk(src_tag[0], 1, "R11", "new mapping");
  endtask

  task automatic t_order;
    do_reset();
    step(1, 1, 0, 0, 0, 0, 0, 0, 0);
    step(1, 1, 1, 0, 0, 0, 0, 0, 0);
    step(1, 1, 2, 0, 0, 0, 0, 0, 0);
    step(0, 0, 0, 0, 0, 1, 2, 2, 32'h2);
    step(0, 0, 0, 0, 0, 1, 0, 0, 32'h0);
    for (int i = 3; i < 16; i++) step(1, 1, 3, 0, 0, 0, 0, 0, 0);
    step(1, 1, 3, 0, 0, 0, 0, 0, 0);
    chk(dst_tag, 2, "R5", "first returned tag");
    step(1, 1, 3, 0, 0, 0, 0, 0, 0);
    chk(dst_tag, 0, "R5", "second returned tag");
    step(1, 1, 3, 0, 0, 0, 0, 0, 0);
    chk(ren_ready, 0, "R5", "pool drained");
  endtask

  initial begin
    #(20 * 100000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    t_reset();
    t_alloc();
    t_self_src();
    t_commit_drain();
    t_younger();
    t_same_cycle();
    t_order();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule